// File: doc/BRIEF.md
# Three-Timer Count Strobe Generator

This block turns one system clock into count-enable strobes for three timer/counters. Timers 0 and 1 draw their divided rates from a single shared free-running prescaler counter, and each has its own 3-bit mode field. A mode can stop the timer, pass every clock, pick one of four divided rates, or count synchronised edges of the timer's own external pin. Timer 2 owns a second prescaler counter with a wider choice of rates. Its advance source is switched by a mode bit: either every system clock, or each rising edge of a slow external oscillator input. That input is synchronised into the system clock domain, so any rate from DC up to 256 kHz works as long as the system clock is much faster.

Every output is a strobe that is high for one system clock per count. The strobes carry no data and have no handshake: a timer samples its strobe on each rising clock edge and counts when it is high. Mode fields are plain control pins and take effect on the strobe in the same cycle.

Top module: `tick_gen`

## Requirements
- R1: A mode field of 000 keeps that timer's strobe low, whatever the prescalers and pins do; all strobes are low while reset is held with mode 000.
- R2: Timer 0/1 mode 001 holds the strobe high on every clock cycle.
- R3: Timer 0/1 modes 010, 011, 100 and 101 give one-cycle strobes spaced exactly 8, 64, 256 and 1024 cycles apart.
- R4: Timers 0 and 1 share one prescaler: with equal divided modes their strobes fall in the same cycles, and each 1024-ratio strobe of one coincides with a 64-ratio strobe of the other.
- R5: Timer 0/1 mode 110 gives one strobe per falling edge of that timer's pin: when the new low level is first sampled at rising edge k, the strobe is high from edge k+1 to edge k+2. Rising pin edges give no strobe.
- R6: Timer 0/1 mode 111 does the same for rising pin edges, with the same latency; falling edges give no strobe.
- R7: With the asynchronous-source bit low, timer 2 mode 001 strobes every cycle and modes 010 to 111 strobe every 8, 32, 64, 128, 256 and 1024 cycles; the oscillator input has no effect in this state.
- R8: With the asynchronous-source bit high, timer 2's prescaler advances once per rising edge of the oscillator input; mode 001 then strobes once per such edge, high from edge k+1 to k+2 when the high level is first sampled at edge k, and the divided modes strobe once per 8, 32, ... oscillator rises. Falling oscillator edges give no strobe.
- R9: Reset clears both prescalers: with timer 0 in mode 010 from reset, the first strobe is high exactly after the 7th rising clock edge that follows reset release, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_sel | input | 3 | Timer 0 mode field |
| t1_sel | input | 3 | Timer 1 mode field |
| t0_pin | input | 1 | Timer 0 external count pin (asynchronous) |
| t1_pin | input | 1 | Timer 1 external count pin (asynchronous) |
| t2_sel | input | 3 | Timer 2 mode field |
| t2_async | input | 1 | Timer 2 source: 0 system clock, 1 slow oscillator |
| t2_osc | input | 1 | Slow oscillator input (asynchronous, DC to 256 kHz) |
| t0_tick | output | 1 | Timer 0 count strobe |
| t1_tick | output | 1 | Timer 1 count strobe |
| t2_tick | output | 1 | Timer 2 count strobe |

## Verification
The edge-origin properties assume that the two pins and the oscillator input sit low through reset, so the synchroniser flops clear to the same level the inputs hold and no phantom edge appears after release. They also assume every level on those inputs lasts longer than the synchroniser depth, so that each strobe maps to exactly one input edge. The stimulus keeps all three asynchronous inputs low during reset, changes the pins at least ten cycles apart, and toggles the oscillator every twenty cycles, which stands in for a slow source against a fast system clock.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

  // Mode field of the two timers fed by the shared prescaler.
  typedef enum logic [2:0] {
    SH_STOP     = 3'd0,
    SH_EVERY    = 3'd1,
    SH_DIV8     = 3'd2,
    SH_DIV64    = 3'd3,
    SH_DIV256   = 3'd4,
    SH_DIV1024  = 3'd5,
    SH_PIN_FALL = 3'd6,
    SH_PIN_RISE = 3'd7
  } sh_mode_e;

  // Mode field of the timer with the private prescaler.
  typedef enum logic [2:0] {
    P2_STOP    = 3'd0,
    P2_EVERY   = 3'd1,
    P2_DIV8    = 3'd2,
    P2_DIV32   = 3'd3,
    P2_DIV64   = 3'd4,
    P2_DIV128  = 3'd5,
    P2_DIV256  = 3'd6,
    P2_DIV1024 = 3'd7
  } p2_mode_e;

  // Number of low prescaler bits that must all be one for each ratio.
  localparam int LOG_DIV8    = 3;
  localparam int LOG_DIV32   = 5;
  localparam int LOG_DIV64   = 6;
  localparam int LOG_DIV128  = 7;
  localparam int LOG_DIV256  = 8;
  localparam int LOG_DIV1024 = 10;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (adv)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_now,
  output logic lvl_prev
);

  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else
      shreg <= {shreg[LAST-1:0], din};
  end

  assign lvl_now  = shreg[LAST-1];
  assign lvl_prev = shreg[LAST];

endmodule

// File: rtl/tick_sel_shared.sv
module tick_sel_shared
  import tick_gen_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] cnt,
  input  logic         pin_now,
  input  logic         pin_prev,
  output logic         tick
);

  logic wrap8, wrap64, wrap256, wrap1024;

  assign wrap8    = &cnt[LOG_DIV8-1:0];
  assign wrap64   = &cnt[LOG_DIV64-1:0];
  assign wrap256  = &cnt[LOG_DIV256-1:0];
  assign wrap1024 = &cnt[LOG_DIV1024-1:0];

  always_comb begin
    unique case (sh_mode_e'(sel))
      SH_STOP:     tick = 1'b0;
      SH_EVERY:    tick = 1'b1;
      SH_DIV8:     tick = wrap8;
      SH_DIV64:    tick = wrap64;
      SH_DIV256:   tick = wrap256;
      SH_DIV1024:  tick = wrap1024;
      SH_PIN_FALL: tick = pin_prev & ~pin_now;
      SH_PIN_RISE: tick = pin_now & ~pin_prev;
      default:     tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tick_sel_t2.sv
module tick_sel_t2
  import tick_gen_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [2:0]   sel,
  input  logic         adv,
  input  logic [W-1:0] cnt,
  output logic         tick
);

  logic w8, w32, w64, w128, w256, w1024;

  assign w8    = adv & (&cnt[LOG_DIV8-1:0]);
  assign w32   = adv & (&cnt[LOG_DIV32-1:0]);
  assign w64   = adv & (&cnt[LOG_DIV64-1:0]);
  assign w128  = adv & (&cnt[LOG_DIV128-1:0]);
  assign w256  = adv & (&cnt[LOG_DIV256-1:0]);
  assign w1024 = adv & (&cnt[LOG_DIV1024-1:0]);

  always_comb begin
    unique case (p2_mode_e'(sel))
      P2_STOP:    tick = 1'b0;
      P2_EVERY:   tick = adv;
      P2_DIV8:    tick = w8;
      P2_DIV32:   tick = w32;
      P2_DIV64:   tick = w64;
      P2_DIV128:  tick = w128;
      P2_DIV256:  tick = w256;
      P2_DIV1024: tick = w1024;
      default:    tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PRE_W       = 10,
  parameter int T2_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] t0_sel,
  input  logic [2:0] t1_sel,
  input  logic       t0_pin,
  input  logic       t1_pin,
  input  logic [2:0] t2_sel,
  input  logic       t2_async,
  input  logic       t2_osc,
  output logic       t0_tick,
  output logic       t1_tick,
  output logic       t2_tick
);

  localparam int N_SHARED = 2;

  // Shared prescaler: advances on every system clock.
  logic [PRE_W-1:0] sh_cnt;

  tick_prescaler #(.W(PRE_W)) u_sh_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (1'b1),
    .cnt   (sh_cnt)
  );

  logic [2:0] sh_sel  [N_SHARED];
  logic       sh_pin  [N_SHARED];
  logic       sh_tick [N_SHARED];

  assign sh_sel[0] = t0_sel;
  assign sh_sel[1] = t1_sel;
  assign sh_pin[0] = t0_pin;
  assign sh_pin[1] = t1_pin;

  for (genvar i = 0; i < N_SHARED; i++) begin : g_shared
    logic pin_now, pin_prev;

    tick_edge_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (sh_pin[i]),
      .lvl_now  (pin_now),
      .lvl_prev (pin_prev)
    );

    tick_sel_shared #(.W(PRE_W)) u_sel (
      .sel      (sh_sel[i]),
      .cnt      (sh_cnt),
      .pin_now  (pin_now),
      .pin_prev (pin_prev),
      .tick     (sh_tick[i])
    );
  end

  assign t0_tick = sh_tick[0];
  assign t1_tick = sh_tick[1];

  // Private prescaler: advances every clock or on each synchronised
  // rising edge of the slow oscillator.
  logic osc_now, osc_prev, t2_adv;
  logic [T2_W-1:0] t2_cnt;

  tick_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (t2_osc),
    .lvl_now  (osc_now),
    .lvl_prev (osc_prev)
  );

  assign t2_adv = t2_async ? (osc_now & ~osc_prev) : 1'b1;

  tick_prescaler #(.W(T2_W)) u_t2_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (t2_adv),
    .cnt   (t2_cnt)
  );

  tick_sel_t2 #(.W(T2_W)) u_t2_sel (
    .sel  (t2_sel),
    .adv  (t2_adv),
    .cnt  (t2_cnt),
    .tick (t2_tick)
  );

endmodule

// File: rtl/tick_gen_checker.sv
module tick_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] t0_sel,
  input logic [2:0] t1_sel,
  input logic       t0_pin,
  input logic       t1_pin,
  input logic [2:0] t2_sel,
  input logic       t2_async,
  input logic       t2_osc,
  input logic       t0_tick,
  input logic       t1_tick,
  input logic       t2_tick
);

  AST_SHARED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_sel == 3'd2 && t1_sel == 3'd2) |-> (t0_tick == t1_tick)); // R4

  AST_NESTED_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_sel == 3'd5 && t1_sel == 3'd3 && t0_tick) |-> t1_tick); // R4

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && t0_sel >= 3'd2) |=> !(t0_tick && t0_sel == $past(t0_sel))); // R3

  AST_RISE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_sel == 3'd7 && t0_tick) |-> ($past(t0_pin, 2) && !$past(t0_pin, 3))); // R6

  AST_FALL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_sel == 3'd6 && t1_tick) |-> (!$past(t1_pin, 2) && $past(t1_pin, 3))); // R5

  AST_OSC_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_async && t2_sel == 3'd1 && t2_tick) |-> ($past(t2_osc, 2) && !$past(t2_osc, 3))); // R8

endmodule

bind tick_gen tick_gen_checker u_tick_gen_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .t0_sel   (t0_sel),
  .t1_sel   (t1_sel),
  .t0_pin   (t0_pin),
  .t1_pin   (t1_pin),
  .t2_sel   (t2_sel),
  .t2_async (t2_async),
  .t2_osc   (t2_osc),
  .t0_tick  (t0_tick),
  .t1_tick  (t1_tick),
  .t2_tick  (t2_tick)
);

// File: tb/tick_gen_bench.sv
`timescale 1ns/1ps
module tick_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] t0_sel = 3'd2;
  logic [2:0] t1_sel = 3'd0;
  logic       t0_pin = 1'b0;
  logic       t1_pin = 1'b0;
  logic [2:0] t2_sel = 3'd0;
  logic       t2_async = 1'b0;
  logic       t2_osc = 1'b0;
  logic       t0_tick, t1_tick, t2_tick;

  int checks = 0;
  int errors = 0;
  bit osc_run = 1'b0;

  always #4 clk = ~clk;

  tick_gen u_tick_gen (
    .clk(clk), .rst_n(rst_n),
    .t0_sel(t0_sel), .t1_sel(t1_sel), .t0_pin(t0_pin), .t1_pin(t1_pin),
    .t2_sel(t2_sel), .t2_async(t2_async), .t2_osc(t2_osc),
    .t0_tick(t0_tick), .t1_tick(t1_tick), .t2_tick(t2_tick)
  );

  // Slow oscillator model: toggles every 20 cycles while enabled.
  initial begin
    forever begin
      repeat (20) @(negedge clk);
      if (osc_run) t2_osc = ~t2_osc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic tk(input int w);
    case (w)
      0: return t0_tick;
      1: return t1_tick;
      default: return t2_tick;
    endcase
  endfunction

  // Finds a strobe, then measures the distance to the next two.
  task automatic measure(input int w, input int exp, input string req);
    int limit = 2 * exp + 200;
    int n;
    bit seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tk(w)) begin seen = 1; break; end
    end
    check(seen, req, 0, 1);
    for (int rep = 0; rep < 2; rep++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!tk(w) && n <= limit);
      check(n == exp, req, n, exp);
    end
  endtask

  // R9 and the reset state of R1
  task automatic t_reset;
    check(t0_tick == 0 && t1_tick == 0 && t2_tick == 0, "R1 reset", int'({t0_tick, t1_tick, t2_tick}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      check(t0_tick == (j == 7), "R9 first strobe", t0_tick, int'(j == 7));
    end
  endtask

  // R1: stop mode ignores everything
  task automatic t_stop;
    int cnt = 0;
    t0_sel = 3'd0; t1_sel = 3'd0; t2_sel = 3'd0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (i % 50 == 0) begin t0_pin = ~t0_pin; t1_pin = ~t1_pin; end
      cnt += t0_tick + t1_tick + t2_tick;
    end
    t0_pin = 1'b0; t1_pin = 1'b0;
    repeat (10) @(negedge clk);
    check(cnt == 0, "R1 stop", cnt, 0);
  endtask

  // R2: every-cycle mode
  task automatic t_every;
    int c0 = 0, c1 = 0;
    t0_sel = 3'd1; t1_sel = 3'd1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      c0 += t0_tick; c1 += t1_tick;
    end
    check(c0 == 50, "R2 timer0", c0, 50);
    check(c1 == 50, "R2 timer1", c1, 50);
    t0_sel = 3'd0; t1_sel = 3'd0;
  endtask

  // R3: shared divided rates
  task automatic t_taps;
    t0_sel = 3'd2; measure(0, 8, "R3 div8");
    t0_sel = 3'd3; measure(0, 64, "R3 div64");
    t0_sel = 3'd4; measure(0, 256, "R3 div256");
    t0_sel = 3'd5; measure(0, 1024, "R3 div1024");
    t0_sel = 3'd0;
    t1_sel = 3'd3; measure(1, 64, "R3 timer1 div64");
    t1_sel = 3'd0;
  endtask

  // R4: one prescaler for both timers
  task automatic t_shared;
    int bad = 0, hits = 0;
    t0_sel = 3'd2; t1_sel = 3'd2;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (t0_tick != t1_tick) bad++;
    end
    check(bad == 0, "R4 same phase", bad, 0);
    t0_sel = 3'd5; t1_sel = 3'd3;
    bad = 0;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk);
      if (t0_tick) begin hits++; if (!t1_tick) bad++; end
    end
    check(hits >= 2 && bad == 0, "R4 nested", bad, 0);
    t0_sel = 3'd0; t1_sel = 3'd0;
  endtask

  // Drives one pin edge and returns the strobe over the next three samples.
  task automatic pin_edge(input int w, input logic val, output logic [2:0] pat);
    if (w == 0) t0_pin = val; else t1_pin = val;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      pat[2-j] = tk(w);
    end
    repeat (10) @(negedge clk);
  endtask

  // R5 on timer 1, R6 on timer 0
  task automatic t_pins;
    logic [2:0] p;
    t1_sel = 3'd6;
    repeat (5) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      pin_edge(1, 1'b1, p); check(p == 3'b000, "R5 rise ignored", p, 0);
      pin_edge(1, 1'b0, p); check(p == 3'b010, "R5 fall strobe", p, 2);
    end
    t1_sel = 3'd0;
    t0_sel = 3'd7;
    repeat (5) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      pin_edge(0, 1'b1, p); check(p == 3'b010, "R6 rise strobe", p, 2);
      pin_edge(0, 1'b0, p); check(p == 3'b000, "R6 fall ignored", p, 0);
    end
    t0_sel = 3'd0;
  endtask

  // R7: timer 2 from the system clock, oscillator running but unused
  task automatic t_t2_sync;
    int c = 0;
    t2_async = 1'b0; osc_run = 1'b1;
    t2_sel = 3'd1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); c += t2_tick; end
    check(c == 100, "R7 every cycle", c, 100);
    t2_sel = 3'd2; measure(2, 8, "R7 div8");
    t2_sel = 3'd3; measure(2, 32, "R7 div32");
    t2_sel = 3'd4; measure(2, 64, "R7 div64");
    t2_sel = 3'd5; measure(2, 128, "R7 div128");
    t2_sel = 3'd6; measure(2, 256, "R7 div256");
    t2_sel = 3'd7; measure(2, 1024, "R7 div1024");
    t2_sel = 3'd0;
  endtask

  // R8: timer 2 from the slow oscillator
  task automatic t_t2_async;
    logic [2:0] p;
    osc_run = 1'b0;
    repeat (2) @(negedge clk);
    t2_osc = 1'b0;
    t2_async = 1'b1; t2_sel = 3'd1;
    repeat (10) @(negedge clk);
    t2_osc = 1'b1;
    for (int j = 0; j < 3; j++) begin @(negedge clk); p[2-j] = t2_tick; end
    check(p == 3'b010, "R8 osc rise latency", p, 2);
    repeat (10) @(negedge clk);
    t2_osc = 1'b0;
    for (int j = 0; j < 3; j++) begin @(negedge clk); p[2-j] = t2_tick; end
    check(p == 3'b000, "R8 osc fall ignored", p, 0);
    osc_run = 1'b1;
    measure(2, 40, "R8 per osc rise");
    t2_sel = 3'd2; measure(2, 320, "R8 div8 of osc");
    t2_sel = 3'd3; measure(2, 1280, "R8 div32 of osc");
    t2_sel = 3'd0;
    osc_run = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_stop();
    t_every();
    t_taps();
    t_shared();
    t_pins();
    t_t2_sync();
    t_t2_async();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule